// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Controller

This block collects five interrupt sources and offers one of them to a processor. There are four edge-triggered pins and one key-wake group. The four pins are two external request lines and two counter-input lines. The key-wake group watches an eight-bit input port. Each source owns a request flag and an enable flag. Each of the four pins also has a polarity bit that picks whether a rising or a falling transition counts. Software reads and writes the flags through a small register bus. The pin detectors run at all times, even when a pin is being used as a plain port input.

A global mask input models the processor's interrupt-disable flag. The block raises its request output when the mask is clear and some source has both flags set. A vector index names the winning source in a fixed priority order. A break input stands for a software break. With the break input high, the vector is valid even while the mask is set, and it names the most urgent pending enabled source. When no source is pending, the vector holds the break's own code. An acknowledge pulse clears the flag of the source that the vector currently names.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After a synchronous reset, the request flags, enable flags and polarity bits are all 0. The irq output is low, vec is 5 and vec_valid is low.
- R2: Bus address 0 holds the request flags and address 1 holds the enable flags. In both, bit 0 is INT0, bit 1 INT1, bit 2 CNTR0, bit 3 CNTR1 and bit 4 key-wake. Address 2 holds the polarity bits in bits 3:0. Unused bits read 0, and address 3 reads 0.
- R3: The signal used for detection is the pin XOR its polarity bit. A 0-to-1 change of that signal sets the pin's request flag, whatever the enable flag holds. With polarity 0 this means a rising pin sets the flag, and with polarity 1 a falling pin sets it. The flag reads 1 after the third rising clock edge that follows the pin change.
- R4: A polarity write that turns the pin XOR polarity signal from 0 to 1 sets the request flag at the clock edge after the write.
- R5: A pin pulse held for at least two clock cycles is captured. This covers a 250 ns pulse at a 4 ns clock.
- R6: While low_power is 1, a low on any key input sets request flag 4. This happens one clock edge after the low has passed the two-stage synchronizer. While low_power is 0, the key inputs have no effect.
- R7: irq is 1 exactly when irq_mask is 0 and at least one source has both its request flag and its enable flag set.
- R8: vec is the lowest-numbered source (0 to 4) with both flags set, or 5 when there is none. vec_valid equals irq OR brk, so a break reports vec even while the mask is set.
- R9: ack clears the request flag of the source named by vec at the next clock edge. If that source sees a new edge in the same cycle, the flag stays set. When vec is 5, ack has no effect.
- R10: A bus write to address 0 replaces all five request flags. It overrides any edge or ack in the same cycle. Writes to other addresses do not block edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | Edge pins: INT0, INT1, CNTR0, CNTR1 |
| key_in | input | KEY_W | Key-wake port inputs, idle high |
| low_power | input | 1 | Device is in stop or wait mode |
| irq_mask | input | 1 | Global interrupt-disable flag |
| brk | input | 1 | Software break in progress |
| ack | input | 1 | Clears the flag of the source named by vec |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request to the processor |
| vec | output | 3 | Winning source index, or 5 for break |
| vec_valid | output | 1 | vec is meaningful (irq or brk) |

## Verification
The bench targets these corner cases:

- Polarity writes that create a spurious request. A design that ignored such writes would leave the flag at 0.
- Falling-edge selection. A design that got it wrong would catch the opposite edge.
- Exact request latency. A wrong pipeline depth moves the flag by a cycle.
- Key lows seen in run mode, which must be ignored. A design that mishandles them would raise wakeups outside low power.
- Break with the mask set, where an ungated vector is needed. A design that gated it would report no source.
- Precedence among write, new edge and ack. A wrong order would lose an event or let an ack undo a software write.

Randomized traffic is then compared cycle by cycle against a reference model built from the requirements.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int N_EDGE  = 4;
    localparam int N_SRC   = N_EDGE + 1;
    localparam int SRC_KEY = N_EDGE;
    localparam int VEC_W   = $clog2(N_SRC + 1);
    localparam logic [VEC_W-1:0] VEC_BRK = VEC_W'(N_SRC);

    typedef enum logic [1:0] {
        RA_REQ  = 2'd0,
        RA_EN   = 2'd1,
        RA_POL  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic             irq;
        logic             valid;
        logic [VEC_W-1:0] vec;
    } grant_t;

    // lowest index wins; break code when nothing is live
    function automatic logic [VEC_W-1:0] pick_first(input src_vec_t live);
        logic [VEC_W-1:0] r;
        r = VEC_BRK;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i]) r = VEC_W'(i);
        end
        return r;
    endfunction

    function automatic src_vec_t vec_onehot(input logic [VEC_W-1:0] v);
        src_vec_t r;
        r = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (v == VEC_W'(i)) r[i] = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
    parameter int SYNC_N = 2,
    parameter int N      = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol,
    output logic [N-1:0] hit
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [SYNC_N-1:0] chain;
        logic              sel;
        logic              sel_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                sel_q <= 1'b0;
            end else begin
                chain <= {chain[SYNC_N-2:0], pin[g]};
                sel_q <= sel;
            end
        end

        // polarity folded in before the edge test, so a polarity flip can fire
        assign sel    = chain[SYNC_N-1] ^ pol[g];
        assign hit[g] = sel & ~sel_q;
    end
endmodule

// File: rtl/irq_key_wake.sv
module irq_key_wake #(
    parameter int SYNC_N = 2,
    parameter int KEY_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] key,
    input  logic             low_power,
    output logic             wake
);
    logic [SYNC_N-1:0][KEY_W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '1;
        else     stg <= {stg[SYNC_N-2:0], key};
    end

    assign wake = low_power & ~(&stg[SYNC_N-1]);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pkg::*;
(
    input  src_vec_t live,
    input  logic     mask,
    input  logic     brk,
    output grant_t   grant
);
    always_comb begin
        grant.irq   = (|live) & ~mask;
        grant.vec   = pick_first(live);
        grant.valid = grant.irq | brk;
    end
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
    import irq_pkg::*;
#(
    parameter int KEY_W  = 8,
    parameter int SYNC_N = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        ext_pin,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              low_power,
    input  logic              irq_mask,
    input  logic              brk,
    input  logic              ack,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [2:0]        vec,
    output logic              vec_valid
);
    src_vec_t          req_q, en_q, set_now, ack_clr, live;
    logic [N_EDGE-1:0] pol_q, edge_hit;
    logic              wake;
    grant_t            grant;
    reg_addr_e         addr;

    assign addr = reg_addr_e'(bus_addr);

    irq_pin_detect #(.SYNC_N(SYNC_N), .N(N_EDGE)) u_pins (
        .clk (clk),
        .rst (rst),
        .pin (ext_pin),
        .pol (pol_q),
        .hit (edge_hit)
    );

    irq_key_wake #(.SYNC_N(SYNC_N), .KEY_W(KEY_W)) u_key (
        .clk       (clk),
        .rst       (rst),
        .key       (key_in),
        .low_power (low_power),
        .wake      (wake)
    );

    assign live = req_q & en_q;

    irq_prio_sel u_sel (
        .live  (live),
        .mask  (irq_mask),
        .brk   (brk),
        .grant (grant)
    );

    assign set_now = {wake, edge_hit};
    assign ack_clr = ack ? vec_onehot(grant.vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            en_q  <= '0;
            pol_q <= '0;
        end else begin
            if (bus_wr && addr == RA_REQ) req_q <= bus_wdata[N_SRC-1:0];
            else                          req_q <= (req_q & ~ack_clr) | set_now;
            if (bus_wr && addr == RA_EN)  en_q  <= bus_wdata[N_SRC-1:0];
            if (bus_wr && addr == RA_POL) pol_q <= bus_wdata[N_EDGE-1:0];
        end
    end

    always_comb begin
        case (addr)
            RA_REQ:  bus_rdata = DATA_W'(req_q);
            RA_EN:   bus_rdata = DATA_W'(en_q);
            RA_POL:  bus_rdata = DATA_W'(pol_q);
            default: bus_rdata = '0;
        endcase
    end

    assign irq       = grant.irq;
    assign vec       = grant.vec;
    assign vec_valid = grant.valid;
endmodule

// File: rtl/irq_edge_ctrl_chk.sv
module irq_edge_ctrl_chk
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              low_power,
    input logic              irq_mask,
    input logic              brk,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [2:0]        vec,
    input logic              vec_valid,
    input src_vec_t          req_q,
    input src_vec_t          en_q
);
    src_vec_t live;
    src_vec_t above;
    assign live  = req_q & en_q;
    assign above = (src_vec_t'(1) << vec) - src_vec_t'(1);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!irq_mask && (live != '0)));

    p_irq_live_r7: assert property (@(posedge clk) disable iff (rst)
        (!irq_mask && (live != '0)) |-> irq);

    p_vec_pick_r8: assert property (@(posedge clk) disable iff (rst)
        (live != '0) |-> (((live & vec_onehot(vec)) != '0) && ((live & above) == '0)));

    p_brk_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (brk && live == '0) |-> (vec == VEC_BRK && vec_valid));

    p_key_run_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q[SRC_KEY]) |-> ($past(low_power) || $past(bus_wr && bus_addr == 2'd0)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (req_q == $past(bus_wdata[N_SRC-1:0])));
endmodule

bind irq_edge_ctrl irq_edge_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .low_power (low_power),
    .irq_mask  (irq_mask),
    .brk       (brk),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .vec       (vec),
    .vec_valid (vec_valid),
    .req_q     (req_q),
    .en_q      (en_q)
);

// File: tb/irq_edge_ctrl_test.sv
`timescale 1ns/100ps
module irq_edge_ctrl_test;
    import irq_pkg::*;
    localparam int KEY_W = 8, SYNC_N = 2, DATA_W = 8;

    logic              clk = 1'b0, rst = 1'b1;
    logic [3:0]        ext_pin = '0;
    logic [KEY_W-1:0]  key_in = '1;
    logic              low_power = 1'b0, irq_mask = 1'b0, brk = 1'b0, ack = 1'b0, bus_wr = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq, vec_valid;
    logic [2:0]        vec;
    int                total = 0, bad = 0;
    bit                finished = 1'b0;

    always #2 clk = ~clk;

    irq_edge_ctrl #(.KEY_W(KEY_W), .SYNC_N(SYNC_N), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .key_in(key_in), .low_power(low_power),
        .irq_mask(irq_mask), .brk(brk), .ack(ack), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .vec(vec), .vec_valid(vec_valid)
    );

    // reference model built from the requirements
    logic [3:0]       m_d1, m_d2, m_sp, m_pol;
    logic [KEY_W-1:0] m_k1, m_k2;
    logic [4:0]       m_req, m_en;

    function automatic logic [2:0] ref_pick(input logic [4:0] lv);
        for (int i = 0; i < 5; i++) if (lv[i]) return 3'(i);
        return 3'd5;
    endfunction

    function automatic logic [DATA_W-1:0] ref_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return DATA_W'(m_req);
            2'd1:    return DATA_W'(m_en);
            2'd2:    return DATA_W'(m_pol);
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [3:0] s, rise;
        logic [4:0] setv, clr;
        logic [2:0] v;
        if (rst) begin
            m_d1 = '0; m_d2 = '0; m_sp = '0; m_pol = '0;
            m_k1 = '1; m_k2 = '1; m_req = '0; m_en = '0;
        end else begin
            s    = m_d2 ^ m_pol;
            rise = s & ~m_sp;
            setv = {low_power & ~(&m_k2), rise};
            v    = ref_pick(m_req & m_en);
            clr  = '0;
            if (ack && v != 3'd5) clr[v] = 1'b1;
            m_sp = s; m_d2 = m_d1; m_d1 = ext_pin; m_k2 = m_k1; m_k1 = key_in;
            if (bus_wr && bus_addr == 2'd0) m_req = bus_wdata[4:0];
            else                            m_req = (m_req & ~clr) | setv;
            if (bus_wr && bus_addr == 2'd1) m_en  = bus_wdata[4:0];
            if (bus_wr && bus_addr == 2'd2) m_pol = bus_wdata[3:0];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        void'($urandom(32'h1d5e_ed01));
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1
        rd(0, d); check("R1 request reset", d, 0);
        rd(1, d); check("R1 enable reset", d, 0);
        rd(2, d); check("R1 polarity reset", d, 0);
        check("R1 irq reset", irq, 0);
        check("R1 vec reset", vec, 5);
        check("R1 vec_valid reset", vec_valid, 0);
        // R2
        wr(1, 8'hFF); rd(1, d); check("R2 enable readback", d, 8'h1F);
        rd(3, d); check("R2 spare address", d, 0);
        // R4: pins low, polarity to 1 makes selected signal rise
        wr(2, 8'hFF); rd(2, d); check("R2 polarity readback", d, 8'h0F);
        rd(0, d); check("R4 not yet set", d, 0);
        tick(); rd(0, d); check("R4 polarity flip sets request", d, 8'h0F);
        wr(2, 8'h00); wr(0, 8'h00);
        rd(0, d); check("R10 software clear", d, 0);
        // R3 rising, timing
        ext_pin[1] = 1'b1;
        tick(); rd(0, d); check("R3 edge +1", d, 0);
        tick(); rd(0, d); check("R3 edge +2", d, 0);
        tick(); rd(0, d); check("R3 rising edge sets on third clock", d, 8'h02);
        check("R7 irq raised", irq, 1);
        check("R8 vec names INT1", vec, 1);
        irq_mask = 1'b1; #0.1;
        check("R7 mask blocks irq", irq, 0);
        check("R8 valid low when masked", vec_valid, 0);
        brk = 1'b1; #0.1;
        check("R8 break valid under mask", vec_valid, 1);
        check("R8 break vec under mask", vec, 1);
        brk = 1'b0; irq_mask = 1'b0;
        ext_pin[0] = 1'b1;
        repeat (3) tick();
        check("R8 INT0 outranks INT1", vec, 0);
        // R9
        ack = 1'b1; tick(); ack = 1'b0;
        rd(0, d); check("R9 ack clears serviced source", d, 8'h02);
        check("R9 vec moves on", vec, 1);
        ack = 1'b1; tick(); ack = 1'b0;
        rd(0, d); check("R9 second ack", d, 0);
        check("R8 vec break code when idle", vec, 5);
        brk = 1'b1; #0.1;
        check("R8 break alone valid", vec_valid, 1);
        brk = 1'b0;
        ack = 1'b1; tick(); ack = 1'b0;
        rd(0, d); check("R9 ack with break code no effect", d, 0);
        // R3 falling
        ext_pin[2] = 1'b1;
        repeat (3) tick();
        rd(0, d); check("R3 CNTR0 rising", d, 8'h04);
        wr(2, 8'h04); wr(0, 8'h00);
        rd(0, d); check("R3 no set on polarity to inactive", d, 0);
        ext_pin[2] = 1'b0;
        tick(); tick(); rd(0, d); check("R3 falling not yet", d, 0);
        tick(); rd(0, d); check("R3 falling edge with polarity 1", d, 8'h04);
        wr(2, 8'h00); wr(0, 8'h00);
        // R5
        ext_pin[3] = 1'b1; tick(); tick(); ext_pin[3] = 1'b0;
        repeat (4) tick();
        rd(0, d); check("R5 two-cycle pulse captured", d, 8'h08);
        ext_pin[1] = 1'b0; repeat (4) tick(); wr(0, 8'h00);
        ext_pin[1] = 1'b1; repeat (63) tick(); ext_pin[1] = 1'b0;
        repeat (4) tick();
        rd(0, d); check("R5 250 ns pulse captured", d, 8'h02);
        wr(0, 8'h00);
        // R6
        key_in = 8'hF7; repeat (5) tick();
        rd(0, d); check("R6 run mode ignores key", d, 0);
        low_power = 1'b1; tick();
        rd(0, d); check("R6 key low wakes in low power", d, 8'h10);
        check("R8 key-wake vec", vec, 4);
        key_in = '1; low_power = 1'b0; repeat (3) tick();
        wr(0, 8'h00);
        // R10
        ext_pin[3] = 1'b1; tick(); tick();
        wr(0, 8'h10);
        rd(0, d); check("R10 write overrides same-cycle edge", d, 8'h10);
        ext_pin[2] = 1'b1; tick(); tick();
        wr(1, 8'h1F);
        rd(0, d); check("R10 other write keeps edge", d, 8'h14);
        ack = 1'b1; wr(0, 8'h04); ack = 1'b0;
        rd(0, d); check("R10 write beats ack", d, 8'h04);
        ext_pin[2] = 1'b0; repeat (3) tick();
        ext_pin[2] = 1'b1; tick(); tick();
        ack = 1'b1; tick(); ack = 1'b0;
        rd(0, d); check("R9 new edge survives ack", d, 8'h04);
        // random phase against model
        for (int n = 0; n < 3000; n++) begin
            #0.1;
            check("R7 irq vs model", irq, (|(m_req & m_en)) && !irq_mask);
            check("R8 vec vs model", vec, ref_pick(m_req & m_en));
            check("R8 vec_valid vs model", vec_valid, ((|(m_req & m_en)) && !irq_mask) || brk);
            check("R2 rdata vs model", bus_rdata, ref_rdata(bus_addr));
            for (int b = 0; b < 4; b++) if ($urandom % 8 == 0) ext_pin[b] = ~ext_pin[b];
            key_in    = ($urandom % 4 == 0) ? KEY_W'($urandom) : '1;
            if ($urandom % 8 == 0) low_power = ~low_power;
            if ($urandom % 6 == 0) irq_mask  = ~irq_mask;
            brk       = ($urandom % 8 == 0);
            ack       = ($urandom % 4 == 0);
            bus_wr    = ($urandom % 6 == 0);
            bus_addr  = 2'($urandom);
            bus_wdata = DATA_W'($urandom);
            tick();
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule